// File: doc/BRIEF.md
# Host Link-Adapter Register File

This block sits on a byte-wide PC I/O bus and exposes a handful of ports through which host software talks to a serial link adapter and steers two control lines of the processor behind it. A port is selected by comparing the full host address with a base address set by a parameter. The default base is 0x150. Six offsets from that base respond. Every other address reads as zero and ignores writes.

The two data offsets pass bytes straight through. A read of the receive offset returns the adapter's byte and pulses an acknowledge in the same cycle. A write to the transmit offset presents the byte with a one-cycle strobe. The two status offsets behave differently for reads and writes. A read returns the adapter flag together with the interrupt enable. A write loads the interrupt enable. The host interrupt is the OR of the two enabled ready conditions.

A further offset serves two purposes. A write to it starts a reset pulse of fixed length for the processor and adapter, and a read returns a sticky error flag. The last offset holds the analyse level.

Top module: `host_link_regs`

## Requirements
- R1: Only the addresses BASE+0x00, +0x01, +0x02, +0x03, +0x10 and +0x11 respond, compared over the full address width. Any other address reads 0x00, and a write to it changes no output or register.
- R2: While `host_rd` is high at BASE+0x00, `host_rdata` equals `rx_data` and `rx_ack` is high in the same cycle. `rx_ack` is low at all other times.
- R3: While `host_wr` is high at BASE+0x01, `tx_wr` is high and `tx_data` equals `host_wdata` in the same cycle. `tx_wr` is low at all other times.
- R4: A read of BASE+0x02 returns bit0 = `rx_valid`, bit1 = input interrupt enable, and bits 7:2 = 0. A write loads the input enable from `host_wdata[0]`, taking effect at the next clock edge.
- R5: A read of BASE+0x03 returns bit0 = `tx_ready`, bit1 = output interrupt enable, and bits 7:2 = 0. A write loads the output enable from `host_wdata[0]`.
- R6: A write to BASE+0x10 drives `link_reset` high from the next clock edge for exactly RST_CYCLES cycles (default 16). A write made during the pulse restarts the count. The write does not change the interrupt enables or `analyse`.
- R7: A read of BASE+0x10 returns the error flag in bit0 and 0 in bits 7:1. The flag is set by any cycle with `err_in` high and stays set. A write to BASE+0x10 clears it, except when `err_in` is high in that same cycle.
- R8: A write to BASE+0x11 loads `analyse` from `host_wdata[0]`. A read of BASE+0x11 returns it in bit0.
- R9: `host_irq` = (`rx_valid` AND input enable) OR (`tx_ready` AND output enable), with no delay.
- R10: After reset, both enables, `analyse`, `link_reset` and the error flag are 0. `host_rdata` is 0x00 whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_rdata | output | 8 | Host read data |
| rx_data | input | 8 | Byte received by the adapter |
| rx_valid | input | 1 | Adapter holds a received byte |
| rx_ack | output | 1 | Received byte taken by the host |
| tx_data | output | 8 | Byte to send |
| tx_wr | output | 1 | Transmit byte strobe |
| tx_ready | input | 1 | Adapter can accept a byte |
| err_in | input | 1 | Error from the attached processor |
| link_reset | output | 1 | Reset pulse to processor and adapter |
| analyse | output | 1 | Analyse control level |
| host_irq | output | 1 | Host interrupt request |

## Verification
The bench sweeps 32 offsets above the base and their copies 0x200 higher. A decoder that compared too few address bits, or let a stray offset through, would either change the enables or `analyse`, or return non-zero read data. All 256 byte values are sent through each data direction, and all 16 combinations of flags and enables are applied to the interrupt, so a swapped term or a status bit in the wrong position shows up at once. The reset pulse is measured cycle by cycle, both alone and when a second write restarts it, which exposes an off-by-one length or a missing reload. The error flag is tested for stickiness and for a clear that must lose to an error arriving in the same cycle.

// File: rtl/host_link_regs.sv
module host_link_regs #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h150,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ack,
  output logic [7:0]        tx_data,
  output logic              tx_wr,
  input  logic              tx_ready,
  input  logic              err_in,
  output logic              link_reset,
  output logic              analyse,
  output logic              host_irq
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_RX   = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_TX   = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IST  = BASE_ADDR + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OST  = BASE_ADDR + ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_RST  = BASE_ADDR + ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_ANA  = BASE_ADDR + ADDR_W'(17);

  logic             in_ie, out_ie, err_flag;
  logic [CNT_W-1:0] rst_cnt;

  wire sel_rx  = host_addr == A_RX;
  wire sel_tx  = host_addr == A_TX;
  wire sel_ist = host_addr == A_IST;
  wire sel_ost = host_addr == A_OST;
  wire sel_rst = host_addr == A_RST;
  wire sel_ana = host_addr == A_ANA;

  assign rx_ack     = host_rd & sel_rx;
  assign tx_wr      = host_wr & sel_tx;
  assign tx_data    = host_wdata;
  assign link_reset = rst_cnt != '0;
  assign host_irq   = (rx_valid & in_ie) | (tx_ready & out_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ie    <= 1'b0;
      out_ie   <= 1'b0;
      analyse  <= 1'b0;
      err_flag <= 1'b0;
      rst_cnt  <= '0;
    end else begin
      if (host_wr && sel_ist) in_ie   <= host_wdata[0];
      if (host_wr && sel_ost) out_ie  <= host_wdata[0];
      if (host_wr && sel_ana) analyse <= host_wdata[0];
      if (err_in)                    err_flag <= 1'b1;
      else if (host_wr && sel_rst)   err_flag <= 1'b0;
      if (host_wr && sel_rst)        rst_cnt <= CNT_W'(RST_CYCLES);
      else if (rst_cnt != '0)        rst_cnt <= rst_cnt - 1'b1;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_rd) begin
      if (sel_rx)       host_rdata = rx_data;
      else if (sel_ist) host_rdata = {6'b0, in_ie, rx_valid};
      else if (sel_ost) host_rdata = {6'b0, out_ie, tx_ready};
      else if (sel_rst) host_rdata = {7'b0, err_flag};
      else if (sel_ana) host_rdata = {7'b0, analyse};
    end
  end
endmodule

// File: rtl/host_link_regs_chk.sv
module host_link_regs_chk #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h150
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic              rx_valid,
  input logic              rx_ack,
  input logic              tx_wr,
  input logic              tx_ready,
  input logic              link_reset,
  input logic              analyse,
  input logic              host_irq
);
  wire wr_rst = host_wr && (host_addr == BASE_ADDR + ADDR_W'(16));
  wire wr_ana = host_wr && (host_addr == BASE_ADDR + ADDR_W'(17));

  // R2
  rx_ack_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> host_rd);
  // R3
  tx_wr_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> host_wr);
  // R6
  reset_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> link_reset);
  // R6
  reset_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rst |=> !$rose(link_reset));
  // R8
  analyse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ana |=> $stable(analyse));
  // R9
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (rx_valid || tx_ready));
endmodule

bind host_link_regs host_link_regs_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
  .rx_valid(rx_valid), .rx_ack(rx_ack), .tx_wr(tx_wr), .tx_ready(tx_ready),
  .link_reset(link_reset), .analyse(analyse), .host_irq(host_irq));

// File: tb/test_host_link_regs.sv
module test_host_link_regs;
  localparam logic [9:0] BASE = 10'h150;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] host_addr = '0;
  logic [7:0] host_wdata = '0, rx_data = '0;
  logic host_wr = 0, host_rd = 0, rx_valid = 0, tx_ready = 0, err_in = 0;
  logic [7:0] host_rdata, tx_data;
  logic rx_ack, tx_wr, link_reset, analyse, host_irq;
  int checks = 0, errors = 0;
  logic seen_txwr, seen_ack;
  logic [7:0] seen_txdata, rd_val;

  always #2 clk = ~clk;

  host_link_regs i_host_link_regs (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1;
    #1 seen_txwr = tx_wr; seen_txdata = tx_data;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(logic [9:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1;
    #1 rd_val = host_rdata; seen_ack = rx_ack;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (link_reset && n < 100) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 link_reset", link_reset, 0);
    chk("R10 analyse", analyse, 0);
    chk("R10 rdata idle", host_rdata, 0);
    rst_n = 1;
    rx_valid = 1; tx_ready = 1;
    #1 chk("R10 irq off", host_irq, 0);
    rd(BASE + 10'h10); chk("R10 err flag", rd_val, 0);
    rd(BASE + 10'h02); chk("R10 in_ie", rd_val, 8'h01);

    // R1 decode sweep
    for (int alias_i = 0; alias_i < 2; alias_i++)
      for (int off = 0; off < 32; off++) begin
        logic [9:0] a;
        a = BASE + 10'(off) + (alias_i ? 10'h200 : 10'h0);
        if (alias_i == 0 && (off < 4 || off == 16 || off == 17)) continue;
        wr(a, 8'hFF);
        chk("R1 tx_wr stray", seen_txwr, 0);
        rd(a);
        chk("R1 stray read", rd_val, 0);
        chk("R1 stray ack", seen_ack, 0);
        chk("R1 link_reset", link_reset, 0);
        chk("R1 analyse", analyse, 0);
        chk("R1 irq", host_irq, 0);
      end

    // R2 receive path
    for (int i = 0; i < 256; i++) begin
      rx_data = 8'(i);
      rd(BASE);
      chk("R2 rdata", rd_val, i);
      chk("R2 ack", seen_ack, 1);
    end
    // R3 transmit path
    for (int i = 0; i < 256; i++) begin
      wr(BASE + 10'h01, 8'(i));
      chk("R3 tx_wr", seen_txwr, 1);
      chk("R3 tx_data", seen_txdata, i);
    end

    // R4 R5 R9 sweep
    for (int c = 0; c < 16; c++) begin
      wr(BASE + 10'h02, {7'b0, c[0]});
      wr(BASE + 10'h03, {7'b0, c[1]});
      rx_valid = c[2]; tx_ready = c[3];
      #1 chk("R9 irq", host_irq, (c[2] & c[0]) | (c[3] & c[1]));
      rd(BASE + 10'h02); chk("R4 in status", rd_val, {c[0], c[2]});
      rd(BASE + 10'h03); chk("R5 out status", rd_val, {c[1], c[3]});
    end
    wr(BASE + 10'h02, 8'h01); wr(BASE + 10'h03, 8'h01);

    // R8 analyse
    wr(BASE + 10'h11, 8'h01);
    chk("R8 analyse set", analyse, 1);
    rd(BASE + 10'h11); chk("R8 readback", rd_val, 1);
    wr(BASE + 10'h11, 8'hFE);
    chk("R8 analyse clear", analyse, 0);
    wr(BASE + 10'h11, 8'h01);

    // R6 pulse length
    wr(BASE + 10'h10, 8'h00);
    pulse_len(n);
    chk("R6 pulse length", n, 16);
    chk("R6 pulse ended", link_reset, 0);
    chk("R6 analyse kept", analyse, 1);
    rd(BASE + 10'h02); chk("R6 enable kept", rd_val, 8'h03);
    wr(BASE + 10'h10, 8'h00);
    repeat (5) @(negedge clk);
    wr(BASE + 10'h10, 8'h00);
    pulse_len(n);
    chk("R6 retrigger length", n, 16);

    // R7 sticky error
    @(negedge clk); err_in = 1; @(negedge clk); err_in = 0;
    repeat (3) @(negedge clk);
    rd(BASE + 10'h10); chk("R7 sticky", rd_val, 1);
    @(negedge clk);
    host_addr = BASE + 10'h10; host_wr = 1; err_in = 1;
    @(negedge clk); host_wr = 0; err_in = 0;
    rd(BASE + 10'h10); chk("R7 set beats clear", rd_val, 1);
    wr(BASE + 10'h10, 8'h00);
    rd(BASE + 10'h10); chk("R7 cleared", rd_val, 0);
    chk("R10 rdata idle again", host_rdata, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule